// File: doc/BRIEF.md
# LCD Refresh Line Scanner and Column Drive Selector

This block runs the refresh side of a dot-matrix LCD column driver. It follows three timing inputs generated elsewhere: a frame pulse, a line clock and an AC-inversion signal. From them it keeps a 5-bit line address. The upper two bits of that address pick one of four pages of the display RAM, and the lower three bits pick a bit within each column's byte. On every rising line clock the block captures one bit per column into a bank of 50 latches. Each column output is then given a 2-bit code that names one of four drive levels. The analog switches that apply those levels are outside this block.

The frame pulse loads the line address with the programmed start page in its two upper bits and zeros below. The 5-bit counter wraps from 31 to 0, so the page scan wraps from page 3 back to page 0. The start page therefore sits at the top of the screen and the other pages follow it in rotation. When the display is turned off, the latch bank is held cleared. Every column then shows the "data 0" level, and the RAM contents are not changed.

All inputs are sampled on the system clock `clk`, and edges of the line clock are found in that clock domain. A two-state phase machine tracks the line clock. In state LINE_LOW, a sampled high level on the line clock raises the capture event and moves the machine to LINE_HIGH. In state LINE_HIGH, a sampled low level raises the advance event and moves the machine back to LINE_LOW. Reset enters LINE_LOW.

Top module: `lcdscan_top`

## Requirements
- R1: During and after reset, with no line-clock edge yet, `line_addr` is 0 and every column code is 2'b11, because the latches are clear and the sampled inversion signal resets to 0.
- R2: While `frm` is high, `line_addr` equals {`start_page`, 3'b000}. A line-clock fall that occurs while `frm` is high does not change it.
- R3: With `frm` low, each falling edge of `cl` adds 1 to `line_addr`, and the value wraps from 31 to 0.
- R4: `rd_page` always presents `line_addr[4:3]`. Column c reads its byte from `rd_data[c*8 +: 8]`.
- R5: On each rising edge of `cl`, latch c captures bit `line_addr[2:0]` of column c's byte. A high pulse captures once only: RAM data that changes while `cl` stays high does not reach the outputs.
- R6: While `disp_on` is 0, all latches are held at 0. After `disp_on` returns to 1, the latches stay 0 until the next rising edge of `cl`.
- R7: Column c's code sits at `drive_lvl[2c +: 2]` and equals {~d, ~m}: 2'b00 for data 1 with m 1, 2'b01 for data 1 with m 0, 2'b10 for data 0 with m 1, 2'b11 for data 0 with m 0.
- R8: With start page s, line k of a frame (k lines after the frame pulse) reads page (s + k/8) mod 4 at bit k mod 8. The scan passes page 3 and continues at page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frm | input | 1 | Frame pulse; while high, the line address is preset |
| cl | input | 1 | Line clock; rise captures data, fall advances the line |
| m | input | 1 | AC-inversion phase |
| start_page | input | 2 | Page shown at the top of the screen |
| disp_on | input | 1 | 1 shows RAM data, 0 forces all columns to the off level |
| rd_page | output | 2 | RAM page being read for the current line |
| rd_data | input | 400 | One byte per column from the selected page |
| line_addr | output | 5 | Current line address |
| drive_lvl | output | 100 | 2-bit drive-level code per column |

## Verification
The bench sweeps every start page through 34 lines. This crosses the page 3 to page 0 wrap and the 31 to 0 wrap. A counter that saturated, or that put the start page in the wrong bits, would show the wrong page or the wrong bit row.

The bench pulses the line clock while the frame pulse is high. A design that let the increment win over the preset would show an address one too high.

The bench changes the RAM data while the line clock is held high. A design that captured on the level of the line clock rather than on its edge would show the new bytes.

The bench also turns the display off and on between line edges. A design that only masked the outputs, instead of clearing the latches, would show old data as soon as the display came back on.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    // Drive-level code per column: {~data, ~m}
    typedef enum logic [1:0] {
        LVL_SEL_POS  = 2'b00,  // data 1, m 1
        LVL_SEL_NEG  = 2'b01,  // data 1, m 0
        LVL_OFF_POS  = 2'b10,  // data 0, m 1
        LVL_OFF_NEG  = 2'b11   // data 0, m 0
    } drive_lvl_e;

    // Phase of the line clock as seen in the system clock domain
    typedef enum logic [0:0] {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_phase_e;

    function automatic drive_lvl_e lvl_of(input logic dbit, input logic mph);
        drive_lvl_e r;
        unique case ({dbit, mph})
            2'b11:   r = LVL_SEL_POS;
            2'b10:   r = LVL_SEL_NEG;
            2'b01:   r = LVL_OFF_POS;
            default: r = LVL_OFF_NEG;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcdscan_in_sync.sv
module lcdscan_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic frm,
    input  logic cl,
    input  logic m,
    output logic frm_q,
    output logic cl_q,
    output logic m_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= 1'b0;
            cl_q  <= 1'b0;
            m_q   <= 1'b0;
        end else begin
            frm_q <= frm;
            cl_q  <= cl;
            m_q   <= m;
        end
    end

endmodule

// File: rtl/lcdscan_phase_fsm.sv
module lcdscan_phase_fsm
    import lcdscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cl_q,
    output logic lat_evt,
    output logic adv_evt
);

    line_phase_e state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LINE_LOW;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            LINE_LOW:  if (cl_q)  state_nx = LINE_HIGH;
            LINE_HIGH: if (!cl_q) state_nx = LINE_LOW;
            default:   state_nx = LINE_LOW;
        endcase
    end

    // Outputs: one event per line-clock edge
    always_comb begin
        lat_evt = 1'b0;
        adv_evt = 1'b0;
        unique case (state)
            LINE_LOW:  lat_evt = cl_q;
            LINE_HIGH: adv_evt = !cl_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/lcdscan_line_ctr.sv
module lcdscan_line_ctr #(
    parameter int PG_W  = 2,
    parameter int BIT_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_q,
    input  logic                    adv_evt,
    input  logic [PG_W-1:0]         start_page,
    output logic [PG_W+BIT_W-1:0]   line_addr
);

    localparam int Z_W = PG_W + BIT_W;

    logic [Z_W-1:0] preset_val;
    assign preset_val = {start_page, {BIT_W{1'b0}}};

    // Preset wins over advance; the counter wraps at its width
    always_ff @(posedge clk) begin
        if (!rst_n)       line_addr <= '0;
        else if (frm_q)   line_addr <= preset_val;
        else if (adv_evt) line_addr <= line_addr + Z_W'(1);
    end

endmodule

// File: rtl/lcdscan_col_latch.sv
module lcdscan_col_latch #(
    parameter int NCOL   = 50,
    parameter int BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lat_evt,
    input  logic                       disp_on,
    input  logic [$clog2(BYTE_W)-1:0]  bit_sel,
    input  logic [NCOL*BYTE_W-1:0]     rd_data,
    output logic [NCOL-1:0]            lat_bits
);

    logic [NCOL-1:0] col_bit;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [BYTE_W-1:0] col_byte;
        assign col_byte   = rd_data[c*BYTE_W +: BYTE_W];
        assign col_bit[c] = col_byte[bit_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !disp_on) lat_bits <= '0;
        else if (lat_evt)       lat_bits <= col_bit;
    end

endmodule

// File: rtl/lcdscan_level_sel.sv
module lcdscan_level_sel
    import lcdscan_pkg::*;
#(
    parameter int NCOL = 50
) (
    input  logic [NCOL-1:0]   lat_bits,
    input  logic              m_q,
    output logic [2*NCOL-1:0] drive_lvl
);

    for (genvar c = 0; c < NCOL; c++) begin : g_lvl
        drive_lvl_e code;
        assign code = lvl_of(lat_bits[c], m_q);
        assign drive_lvl[2*c +: 2] = code;
    end

endmodule

// File: rtl/lcdscan_top.sv
module lcdscan_top
    import lcdscan_pkg::*;
#(
    parameter int NCOL   = 50,
    parameter int BYTE_W = 8,
    parameter int NPAGE  = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      frm,
    input  logic                                      cl,
    input  logic                                      m,
    input  logic [$clog2(NPAGE)-1:0]                  start_page,
    input  logic                                      disp_on,
    output logic [$clog2(NPAGE)-1:0]                  rd_page,
    input  logic [NCOL*BYTE_W-1:0]                    rd_data,
    output logic [$clog2(NPAGE)+$clog2(BYTE_W)-1:0]   line_addr,
    output logic [2*NCOL-1:0]                         drive_lvl
);

    localparam int PG_W  = $clog2(NPAGE);
    localparam int BIT_W = $clog2(BYTE_W);

    logic            frm_q, cl_q, m_q;
    logic            lat_evt, adv_evt;
    logic [NCOL-1:0] lat_bits;

    lcdscan_in_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .frm   (frm),
        .cl    (cl),
        .m     (m),
        .frm_q (frm_q),
        .cl_q  (cl_q),
        .m_q   (m_q)
    );

    lcdscan_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cl_q    (cl_q),
        .lat_evt (lat_evt),
        .adv_evt (adv_evt)
    );

    lcdscan_line_ctr #(.PG_W(PG_W), .BIT_W(BIT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_q      (frm_q),
        .adv_evt    (adv_evt),
        .start_page (start_page),
        .line_addr  (line_addr)
    );

    assign rd_page = line_addr[BIT_W +: PG_W];

    lcdscan_col_latch #(.NCOL(NCOL), .BYTE_W(BYTE_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_evt  (lat_evt),
        .disp_on  (disp_on),
        .bit_sel  (line_addr[BIT_W-1:0]),
        .rd_data  (rd_data),
        .lat_bits (lat_bits)
    );

    lcdscan_level_sel #(.NCOL(NCOL)) u_lvl (
        .lat_bits  (lat_bits),
        .m_q       (m_q),
        .drive_lvl (drive_lvl)
    );

endmodule

// File: rtl/lcdscan_chk.sv
module lcdscan_chk #(
    parameter int NCOL = 50,
    parameter int Z_W  = 5,
    parameter int PG_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frm_q,
    input logic            lat_evt,
    input logic            adv_evt,
    input logic            disp_on,
    input logic [PG_W-1:0] start_page,
    input logic [Z_W-1:0]  line_addr,
    input logic [NCOL-1:0] lat_bits
);

    // R2
    frame_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q |=> line_addr == {$past(start_page), {(Z_W-PG_W){1'b0}}});

    // R3
    line_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_evt && !frm_q) |=> line_addr == $past(line_addr) + Z_W'(1));

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_evt && !frm_q) |=> $stable(line_addr));

    // R5
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_evt |=> !lat_evt);

    // R5
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lat_evt && adv_evt));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_on && !lat_evt) |=> $stable(lat_bits));

    // R6
    blank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> lat_bits == '0);

endmodule

bind lcdscan_top lcdscan_chk #(
    .NCOL (NCOL),
    .Z_W  ($clog2(NPAGE) + $clog2(BYTE_W)),
    .PG_W ($clog2(NPAGE))
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_q      (frm_q),
    .lat_evt    (lat_evt),
    .adv_evt    (adv_evt),
    .disp_on    (disp_on),
    .start_page (start_page),
    .line_addr  (line_addr),
    .lat_bits   (lat_bits)
);

// File: tb/lcdscan_top_tb_top.sv
module lcdscan_top_tb_top;

    localparam int NCOL = 50;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frm = 1'b0, cl = 1'b0, m = 1'b0, disp_on = 1'b1;
    logic [1:0]         start_page = 2'd0;
    logic [1:0]         rd_page;
    logic [NCOL*8-1:0]  rd_data;
    logic [4:0]         line_addr;
    logic [2*NCOL-1:0]  drive_lvl;
    int                 salt = 0;
    int                 checks = 0, failures = 0;
    bit                 timed_out = 1'b0;

    always #2.5 clk = ~clk;

    lcdscan_top dut_i (
        .clk(clk), .rst_n(rst_n), .frm(frm), .cl(cl), .m(m),
        .start_page(start_page), .disp_on(disp_on), .rd_page(rd_page),
        .rd_data(rd_data), .line_addr(line_addr), .drive_lvl(drive_lvl)
    );

    function automatic logic [7:0] ram_byte(int p, int c, int s);
        return 8'((p*67 + c*13 + 5 + s*29) ^ ((c*5 + p*3) & 255));
    endfunction

    // RAM model: combinational read of the requested page
    always_comb begin
        for (int c = 0; c < NCOL; c++)
            rd_data[c*8 +: 8] = ram_byte(int'(rd_page), c, salt);
    end

    function automatic logic [2*NCOL-1:0] exp_drive(int z, logic mph, logic on, int s);
        logic [2*NCOL-1:0] r;
        for (int c = 0; c < NCOL; c++) begin
            logic [7:0] b;
            logic d;
            b = ram_byte((z / 8) % 4, c, s);
            d = on ? b[z % 8] : 1'b0;
            r[2*c +: 2] = {~d, ~mph};
        end
        return r;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_addr(string req, int exp);
        checks++;
        if (line_addr !== 5'(exp)) begin
            failures++;
            $display("FAIL %s line_addr actual=%0d expected=%0d", req, line_addr, exp);
        end
    endtask

    task automatic chk_drive(string req, logic [2*NCOL-1:0] exp);
        checks++;
        if (drive_lvl !== exp) begin
            failures++;
            $display("FAIL %s drive_lvl actual=%h expected=%h", req, drive_lvl, exp);
        end
    endtask

    task automatic chk_page(string req, int z);
        checks++;
        if (rd_page !== 2'((z / 8) % 4)) begin
            failures++;
            $display("FAIL %s rd_page actual=%0d expected=%0d", req, rd_page, (z / 8) % 4);
        end
    endtask

    // Preset with start page sp, then scan nl lines
    task automatic run_frame(int sp, int nl);
        int z;
        start_page = 2'(sp);
        cl = 1'b0;
        frm = 1'b1;
        step(3);
        chk_addr("R2 preset", sp * 8);
        cl = 1'b1; step(3);
        cl = 1'b0; step(3);
        chk_addr("R2 fall ignored during frame", sp * 8);
        frm = 1'b0;
        step(2);
        z = sp * 8;
        for (int k = 0; k < nl; k++) begin
            m = k[0];
            cl = 1'b1;
            step(3);
            chk_page("R4 page select", z);
            chk_drive("R8 R5 R7 line data", exp_drive(z, k[0], 1'b1, salt));
            cl = 1'b0;
            step(3);
            z = (z + 1) % 32;
            chk_addr("R3 advance", z);
        end
    endtask

    task automatic run_all();
        int z;
        step(4);
        chk_addr("R1 in reset", 0);
        chk_drive("R1 in reset", {NCOL{2'b11}});
        rst_n = 1'b1;
        step(3);
        chk_addr("R1 after reset", 0);
        chk_drive("R1 after reset", {NCOL{2'b11}});

        for (int sp = 0; sp < 4; sp++) run_frame(sp, 34);

        // Capture once per high pulse: RAM change while high is not seen (R5)
        salt = 1;
        run_frame(2, 3);
        z = 19;
        m = 1'b1;
        cl = 1'b1;
        step(3);
        chk_drive("R5 capture", exp_drive(z, 1'b1, 1'b1, 1));
        salt = 2;
        step(4);
        chk_drive("R5 hold while high", exp_drive(z, 1'b1, 1'b1, 1));
        m = 1'b0;
        step(3);
        chk_drive("R7 m flip", exp_drive(z, 1'b0, 1'b1, 1));
        cl = 1'b0;
        step(3);
        z = 20;

        // Display off clears latches; on again waits for the next rise (R6)
        disp_on = 1'b0;
        step(3);
        chk_drive("R6 off clears", {NCOL{2'b11}});
        m = 1'b1;
        cl = 1'b1; step(3);
        chk_drive("R6 off during rise", {NCOL{2'b10}});
        cl = 1'b0; step(3);
        z = 21;
        disp_on = 1'b1;
        step(3);
        chk_drive("R6 on before rise", {NCOL{2'b10}});
        chk_addr("R6 address keeps running", z);
        cl = 1'b1; step(3);
        chk_drive("R6 on after rise", exp_drive(z, 1'b1, 1'b1, 2));
        cl = 1'b0; step(3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule